// File: doc/BRIEF.md
# Random Tag Shift-Register Generator

This block holds a 16-bit pseudo-random state and turns it into 4-bit tags on demand. Each generation request runs four shift-register steps in one clock: every step forms a feedback bit from a fixed set of state bits, shifts the state one place toward bit 0 and inserts the feedback bit at the top. The four feedback bits, in the order they are produced, make up the tag.

Software or a neighbouring unit can load the state at any time through a write port and can observe the current state at all times. A write wins over a request in the same cycle. The block does not filter tags and does not reseed itself: an all-zero state stays locked at zero.

Top module: `rtag_lfsr_top`

## Requirements
- R1: After reset, `state_o` is 16'h0001, `tag_o` is 4'b0000 and `tag_vld_o` is 0.
- R2: One step computes fb = s[5]^s[3]^s[2]^s[0] and produces the state {fb, s[15:1]}. From 16'h0001 a request therefore yields the state 16'h1000.
- R3: When `gen_req` is high and `load_en` is low at a rising edge, `state_o` shows the result of four consecutive steps after that edge.
- R4: The tag from such a request holds the first step's feedback bit in bit 0 and the fourth step's feedback bit in bit 3. It appears on `tag_o` after the same edge as the new state.
- R5: When `load_en` is high at a rising edge, `state_o` equals `load_data` after that edge, whatever `gen_req` is. `tag_o` keeps its value and `tag_vld_o` is 0.
- R6: A request made while the state is all zeros leaves the state at zero and gives tag 4'b0000.
- R7: With `gen_req` and `load_en` both low at an edge, `state_o` and `tag_o` keep their values.
- R8: `tag_vld_o` is high for exactly the cycle after each accepted request (`gen_req` high, `load_en` low), and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gen_req | input | 1 | Produce one tag and advance the state four steps |
| load_en | input | 1 | Load `load_data` into the state; wins over `gen_req` |
| load_data | input | 16 | Value for the state on a load |
| tag_o | output | 4 | Most recent tag |
| tag_vld_o | output | 1 | High for one cycle after an accepted request |
| state_o | output | 16 | Current state |

## Verification
The bench uses the default parameters: a 16-bit state, 4-bit tags, feedback taps at bits 5, 3, 2 and 0, and reset value 16'h0001. With these values the short directed sequence from the reset value, the zero-state lock and collisions between a load and a request can all be checked exactly. A long random run with occasional loads of arbitrary values covers many start states, so that every tap position and every tag bit is seen to affect the result.

// File: rtl/rtag_lfsr_pkg.sv
package rtag_lfsr_pkg;

    localparam int unsigned STATE_W_DEF = 16;
    localparam int unsigned TAG_W_DEF   = 4;

    // Feedback taps at state bits 5, 3, 2 and 0.
    localparam logic [STATE_W_DEF-1:0] TAPS_DEF  = 16'h002D;
    localparam logic [STATE_W_DEF-1:0] RESET_DEF = 16'h0001;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_GEN  = 2'd2
    } rtag_op_e;

endpackage

// File: rtl/rtag_lfsr_step.sv
module rtag_lfsr_step #(
    parameter int unsigned          STATE_W = 16,
    parameter logic [STATE_W-1:0]   TAPS    = 16'h002D
) (
    input  logic [STATE_W-1:0] cur_i,
    output logic [STATE_W-1:0] nxt_o,
    output logic               fb_o
);

    always_comb begin
        fb_o  = ^(cur_i & TAPS);
        nxt_o = {fb_o, cur_i[STATE_W-1:1]};
    end

endmodule

// File: rtl/rtag_lfsr_unroll.sv
module rtag_lfsr_unroll #(
    parameter int unsigned          STATE_W = 16,
    parameter int unsigned          STEPS   = 4,
    parameter logic [STATE_W-1:0]   TAPS    = 16'h002D
) (
    input  logic [STATE_W-1:0] start_i,
    output logic [STATE_W-1:0] end_o,
    output logic [STEPS-1:0]   bits_o
);

    logic [STATE_W-1:0] chain [0:STEPS];

    assign chain[0] = start_i;

    for (genvar k = 0; k < STEPS; k++) begin : g_stage
        // The feedback of stage k becomes output bit k, first stage in bit 0.
        rtag_lfsr_step #(
            .STATE_W (STATE_W),
            .TAPS    (TAPS)
        ) u_step (
            .cur_i (chain[k]),
            .nxt_o (chain[k+1]),
            .fb_o  (bits_o[k])
        );
    end

    assign end_o = chain[STEPS];

endmodule

// File: rtl/rtag_lfsr_top.sv
module rtag_lfsr_top
    import rtag_lfsr_pkg::*;
#(
    parameter int unsigned                STATE_W = STATE_W_DEF,
    parameter int unsigned                TAG_W   = TAG_W_DEF,
    parameter logic [STATE_W_DEF-1:0]     TAPS    = TAPS_DEF,
    parameter logic [STATE_W_DEF-1:0]     RST_VAL = RESET_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               gen_req,
    input  logic               load_en,
    input  logic [STATE_W-1:0] load_data,
    output logic [TAG_W-1:0]   tag_o,
    output logic               tag_vld_o,
    output logic [STATE_W-1:0] state_o
);

    localparam int unsigned SHIFT_KEEP = STATE_W - TAG_W;

    typedef struct packed {
        logic [STATE_W-1:0] state;
        logic [TAG_W-1:0]   tag;
        logic               vld;
    } regs_t;

    regs_t    r_d, r_q;
    rtag_op_e op;

    logic [STATE_W-1:0] adv_state;
    logic [TAG_W-1:0]   adv_bits;

    rtag_lfsr_unroll #(
        .STATE_W (STATE_W),
        .STEPS   (TAG_W),
        .TAPS    (TAPS[STATE_W-1:0])
    ) u_unroll (
        .start_i (r_q.state),
        .end_o   (adv_state),
        .bits_o  (adv_bits)
    );

    always_comb begin
        if (load_en)      op = OP_LOAD;
        else if (gen_req) op = OP_GEN;
        else              op = OP_HOLD;

        r_d     = r_q;
        r_d.vld = 1'b0;
        case (op)
            OP_LOAD: r_d.state = load_data;
            OP_GEN: begin
                r_d.state = adv_state;
                r_d.tag   = adv_bits;
                r_d.vld   = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= RST_VAL[STATE_W-1:0];
            r_q.tag   <= '0;
            r_q.vld   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o   = r_q.state;
    assign tag_o     = r_q.tag;
    assign tag_vld_o = r_q.vld;

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (state_o == $past(load_data)) && !tag_vld_o && $stable(tag_o)); // R5

    AST_SHIFT_FOUR: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_req && !load_en) |=> state_o[SHIFT_KEEP-1:0] == $past(state_o[STATE_W-1:TAG_W])); // R3

    AST_ZERO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_req && !load_en && state_o == '0) |=> (state_o == '0) && (tag_o == '0)); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!gen_req && !load_en) |=> $stable(state_o) && $stable(tag_o)); // R7

    AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_req && !load_en) |=> tag_vld_o); // R8

    AST_VLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!gen_req || load_en) |=> !tag_vld_o); // R8

endmodule

// File: tb/tb_rtag_lfsr_top.sv
module tb_rtag_lfsr_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        gen_req;
    logic        load_en;
    logic [15:0] load_data;
    logic [3:0]  tag_o;
    logic        tag_vld_o;
    logic [15:0] state_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    logic [15:0] m_state;
    logic [3:0]  m_tag;
    logic        m_vld;

    always #10 clk = ~clk;

    rtag_lfsr_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .gen_req   (gen_req),
        .load_en   (load_en),
        .load_data (load_data),
        .tag_o     (tag_o),
        .tag_vld_o (tag_vld_o),
        .state_o   (state_o)
    );

    function automatic logic [19:0] model_gen(input logic [15:0] s);
        logic [15:0] st = s;
        logic [3:0]  t  = '0;
        for (int i = 0; i < 4; i++) begin
            logic fb;
            fb   = st[5] ^ st[3] ^ st[2] ^ st[0];
            t[i] = fb;
            st   = {fb, st[15:1]};
        end
        return {st, t};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Apply one cycle of stimulus and update the model.
    task automatic step(input logic g, input logic l, input logic [15:0] d);
        logic [19:0] r;
        @(negedge clk);
        gen_req = g; load_en = l; load_data = d;
        @(posedge clk);
        #1;
        if (l) begin
            m_state = d; m_vld = 1'b0;
        end else if (g) begin
            r = model_gen(m_state);
            m_state = r[19:4]; m_tag = r[3:0]; m_vld = 1'b1;
        end else begin
            m_vld = 1'b0;
        end
    endtask

    task automatic check_all(input string tag_req, input string st_req);
        check(st_req, 32'(state_o), 32'(m_state));
        check(tag_req, 32'(tag_o), 32'(m_tag));
        check("R8", 32'(tag_vld_o), 32'(m_vld));
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        rst_n = 1'b0; gen_req = 1'b0; load_en = 1'b0; load_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1", 32'(state_o), 32'h0001);
        check("R1", 32'(tag_o), 32'h0);
        check("R1", 32'(tag_vld_o), 32'h0);
        m_state = 16'h0001; m_tag = '0; m_vld = 1'b0;

        // R2 / R4 known vector: 0001 -> 1000 with tag 0001
        step(1'b1, 1'b0, 16'h0);
        check("R2", 32'(state_o), 32'h1000);
        check("R4", 32'(tag_o), 32'h1);
        check("R8", 32'(tag_vld_o), 32'h1);

        // R7 idle holds
        step(1'b0, 1'b0, 16'hFFFF);
        check_all("R7", "R7");

        // R5 load wins over request
        step(1'b1, 1'b1, 16'hACE1);
        check_all("R5", "R5");

        // R3 / R4 from a loaded value
        step(1'b1, 1'b0, 16'h0);
        check_all("R4", "R3");

        // R6 zero lock
        step(1'b0, 1'b1, 16'h0000);
        check_all("R5", "R5");
        step(1'b1, 1'b0, 16'h0);
        check("R6", 32'(state_o), 32'h0);
        check("R6", 32'(tag_o), 32'h0);
        step(1'b1, 1'b0, 16'h0);
        check_all("R6", "R6");

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            int unsigned sel = $urandom_range(0, 99);
            logic g = (sel < 70);
            logic l = (sel >= 90) || (sel < 4);
            logic [15:0] d = (sel == 95) ? 16'h0000 : 16'($urandom);
            step(g, l, d);
            if (l)      check_all("R5", "R5");
            else if (g) check_all("R4", "R3");
            else        check_all("R7", "R7");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule